// File: doc/BRIEF.md
# Hint-Seeded Two-Bit Branch Direction Table

This block holds a direct-mapped table of two-bit saturating direction counters, one per entry, selected by a slice of the fetch address. When a branch is first installed, its entry is written through a seeding port. A branch that carries a static direction hint starts in the weak state on the side of that hint. A branch that carries no hint always starts weak not-taken. From then on the entry only moves through resolved outcomes.

A lookup port returns the predicted direction for any index in the same cycle, from the state written at the last clock edge. An outcome port applies a resolved taken or not-taken result to an entry and moves it one step toward the matching strong end. A loop that has saturated toward taken therefore survives a single exit without flipping. Every outcome that disagrees with the stored prediction raises a one-cycle flag and bumps a saturating event counter.

Seeding and outcomes can target different entries in the same cycle, and both take effect. When they hit the same entry, the seed wins.

Top module: `hint_bpt`

## Requirements
- R1: A synchronous reset puts every entry in weak not-taken (2'b01), clears `miss_count` to zero and drives `upd_mispredict` low.
- R2: A seed with `seed_has_hint`=1 writes weak taken (2'b10) when `seed_hint_taken`=1, and weak not-taken (2'b01) when `seed_hint_taken`=0.
- R3: A seed with `seed_has_hint`=0 writes weak not-taken whatever the value of `seed_hint_taken`.
- R4: `lkp_taken` is the high bit of the addressed state: 1 for 2'b11 (strong taken) and 2'b10 (weak taken), 0 for 2'b01 and 2'b00 (strong not-taken).
- R5: An outcome of taken moves the entry one step toward 2'b11, and an outcome of not-taken moves it one step toward 2'b00, holding at either end. From strong taken, two not-taken outcomes are needed before the prediction turns.
- R6: When a seed and an outcome name the same index in one cycle, the entry takes the seed value. When they name different indices, both entries are written.
- R7: `upd_mispredict` is high in the cycle after an outcome whose direction differs from the prediction stored before that edge, and low after any cycle with no outcome.
- R8: `miss_count` rises by one at each edge where a misprediction is detected and holds at its all-ones maximum.
- R9: `lkp_taken` is combinational in `lkp_idx` and reflects every write made at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_en | input | 1 | Write a fresh entry |
| seed_idx | input | IDX_W | Entry to seed |
| seed_has_hint | input | 1 | The branch carries a static direction hint |
| seed_hint_taken | input | 1 | Hint direction, used only when a hint is present |
| lkp_idx | input | IDX_W | Entry to predict |
| lkp_taken | output | 1 | Predicted direction for `lkp_idx` |
| upd_en | input | 1 | Apply a resolved outcome |
| upd_idx | input | IDX_W | Entry the outcome belongs to |
| upd_taken | input | 1 | Resolved direction, 1 means taken |
| upd_mispredict | output | 1 | Registered flag: the last outcome disagreed with the prediction |
| miss_count | output | CNT_W | Saturating count of mispredictions |

## Verification
The bench walks one entry through every state in both directions. Saturating pushes at each end catch a counter that wraps from strong taken to strong not-taken. A run of exactly two not-taken outcomes from strong taken shows whether a design flips after one. Unhinted seeds drive the hint bit high, so a design that ignores the presence flag would seed weak taken. Colliding and non-colliding seed/outcome pairs separate a design that lets the outcome win, or that drops one of the two writes. The event counter is driven past its maximum and would wrap back to a small value if saturation were missing.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef logic [1:0] bstate_t;

  localparam bstate_t ST_SNT = 2'b00;
  localparam bstate_t ST_WNT = 2'b01;
  localparam bstate_t ST_WTK = 2'b10;
  localparam bstate_t ST_STK = 2'b11;

  // one saturating step toward the resolved direction
  function automatic bstate_t step_state(input bstate_t s, input logic taken);
    bstate_t r;
    if (taken) r = (s == ST_STK) ? ST_STK : s + 2'd1;
    else       r = (s == ST_SNT) ? ST_SNT : s - 2'd1;
    return r;
  endfunction

  // initial state for a freshly installed branch
  function automatic bstate_t seed_state(input logic has_hint, input logic hint_taken);
    return (has_hint && hint_taken) ? ST_WTK : ST_WNT;
  endfunction
endpackage

// File: rtl/bpt_step.sv
module bpt_step
  import bpt_pkg::*;
(
  input  bstate_t cur,
  input  logic    taken,
  output bstate_t nxt,
  output logic    miss
);
  always_comb begin
    nxt  = step_state(cur, taken);
    miss = (cur[1] != taken);
  end
endmodule

// File: rtl/bpt_table.sv
module bpt_table
  import bpt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  bstate_t          wa_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  bstate_t          wb_data,
  input  logic [IDX_W-1:0] ra_idx,
  output bstate_t          ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output bstate_t          rb_data
);
  localparam int DEPTH = 1 << IDX_W;

  bstate_t mem [DEPTH];

  // port A (seed) has priority over port B (outcome) on the same entry
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        mem[gi] <= ST_WNT;
      else if (wa_en && (wa_idx == IDX_W'(gi)))
        mem[gi] <= wa_data;
      else if (wb_en && (wb_idx == IDX_W'(gi)))
        mem[gi] <= wb_data;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];

  assert_seed_wins_R6: assert property (@(posedge clk) disable iff (rst)
    wa_en |=> (mem[$past(wa_idx)] == $past(wa_data)));

  assert_step_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !(wa_en && wa_idx == wb_idx)) |=>
      ($past(wb_data) == mem[$past(wb_idx)]));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mem[0] == ST_WNT && mem[DEPTH-1] == ST_WNT));
endmodule

// File: rtl/bpt_sat_counter.sv
module bpt_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                      value <= '0;
    else if (inc && value != MAXV) value <= value + 1'b1;
  end

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(value));

  assert_count_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && value == MAXV) |=> (value == MAXV));

  assert_count_inc_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && value != MAXV) |=> (value == $past(value) + 1'b1));
endmodule

// File: rtl/hint_bpt.sv
module hint_bpt
  import bpt_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_en,
  input  logic [IDX_W-1:0] seed_idx,
  input  logic             seed_has_hint,
  input  logic             seed_hint_taken,
  input  logic [IDX_W-1:0] lkp_idx,
  output logic             lkp_taken,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output logic             upd_mispredict,
  output logic [CNT_W-1:0] miss_count
);
  bstate_t seed_val, lkp_state, upd_cur, upd_nxt;
  logic    upd_miss_raw, miss_now;

  assign seed_val = seed_state(seed_has_hint, seed_hint_taken);

  bpt_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (seed_en),
    .wa_idx  (seed_idx),
    .wa_data (seed_val),
    .wb_en   (upd_en),
    .wb_idx  (upd_idx),
    .wb_data (upd_nxt),
    .ra_idx  (lkp_idx),
    .ra_data (lkp_state),
    .rb_idx  (upd_idx),
    .rb_data (upd_cur)
  );

  bpt_step u_step (
    .cur   (upd_cur),
    .taken (upd_taken),
    .nxt   (upd_nxt),
    .miss  (upd_miss_raw)
  );

  assign miss_now  = upd_en && upd_miss_raw;
  assign lkp_taken = lkp_state[1];

  always_ff @(posedge clk) begin
    if (rst) upd_mispredict <= 1'b0;
    else     upd_mispredict <= miss_now;
  end

  bpt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (miss_now),
    .value (miss_count)
  );

  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> (miss_count == '0 && !upd_mispredict));

  assert_no_flag_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> !upd_mispredict);

  assert_flag_counts_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_mispredict && $past(miss_count) != '1) |-> (miss_count != $past(miss_count)));

  assert_unhinted_seed_R3: assert property (@(posedge clk) disable iff (rst)
    (seed_en && !seed_has_hint) |=> (u_table.mem[$past(seed_idx)] == ST_WNT));

  assert_pred_msb_R4: assert property (@(posedge clk) disable iff (rst)
    (lkp_state == ST_STK || lkp_state == ST_WTK) |-> lkp_taken);
endmodule

// File: tb/hint_bpt_tb.sv
module hint_bpt_tb;
  localparam int IDX_W = 5;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst;
  logic seed_en, seed_has_hint, seed_hint_taken;
  logic [IDX_W-1:0] seed_idx, lkp_idx, upd_idx;
  logic lkp_taken, upd_en, upd_taken, upd_mispredict;
  logic [CNT_W-1:0] miss_count;

  int n_run = 0;
  int n_fail = 0;
  logic [CNT_W-1:0] exp_cnt = '0;

  always #4 clk = ~clk;

  hint_bpt #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst),
    .seed_en(seed_en), .seed_idx(seed_idx),
    .seed_has_hint(seed_has_hint), .seed_hint_taken(seed_hint_taken),
    .lkp_idx(lkp_idx), .lkp_taken(lkp_taken),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .miss_count(miss_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a falling edge, check after the rising edge
  task automatic op(input logic ie, input logic hh, input logic h, input logic [IDX_W-1:0] ii,
                    input logic ue, input logic ut, input logic [IDX_W-1:0] ui,
                    input logic [IDX_W-1:0] ci, input logic ep, input logic em,
                    input string req);
    @(negedge clk);
    seed_en = ie; seed_has_hint = hh; seed_hint_taken = h; seed_idx = ii;
    upd_en = ue; upd_taken = ut; upd_idx = ui;
    @(negedge clk);
    seed_en = 1'b0; upd_en = 1'b0;
    lkp_idx = ci;
    #1;
    if (em) exp_cnt = (exp_cnt == CMAX) ? CMAX : exp_cnt + 1'b1;
    check({req, " pred"}, int'(lkp_taken), int'(ep));
    check("R7 mispredict flag", int'(upd_mispredict), int'(em));
    check("R8 miss count", int'(miss_count), int'(exp_cnt));
  endtask

  // vector: seed_en, has_hint, hint, upd_en, upd_taken, idx[4:0], exp_pred, exp_miss
  localparam int NV = 15;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1, 1'b0,1'b0, 5'd3, 1'b1,1'b0},  // R2 hinted taken -> weak taken
    {1'b0,1'b0,1'b0, 1'b1,1'b1, 5'd3, 1'b1,1'b0},  // R5 -> strong taken
    {1'b0,1'b0,1'b0, 1'b1,1'b1, 5'd3, 1'b1,1'b0},  // R5 saturate high
    {1'b0,1'b0,1'b0, 1'b1,1'b0, 5'd3, 1'b1,1'b1},  // R5 first not-taken keeps taken
    {1'b0,1'b0,1'b0, 1'b1,1'b0, 5'd3, 1'b0,1'b1},  // R5 second flips
    {1'b0,1'b0,1'b0, 1'b1,1'b0, 5'd3, 1'b0,1'b0},  // R5 -> strong not-taken
    {1'b0,1'b0,1'b0, 1'b1,1'b0, 5'd3, 1'b0,1'b0},  // R5 saturate low
    {1'b0,1'b0,1'b0, 1'b1,1'b1, 5'd3, 1'b0,1'b1},  // R5 -> weak not-taken
    {1'b0,1'b0,1'b0, 1'b1,1'b1, 5'd3, 1'b1,1'b1},  // R5 -> weak taken
    {1'b1,1'b0,1'b1, 1'b0,1'b0, 5'd5, 1'b0,1'b0},  // R3 no hint, hint bit high
    {1'b1,1'b1,1'b0, 1'b0,1'b0, 5'd5, 1'b0,1'b0},  // R2 hinted not-taken
    {1'b0,1'b0,1'b0, 1'b1,1'b1, 5'd5, 1'b1,1'b1},  // R5 weak not-taken -> weak taken
    {1'b1,1'b1,1'b1, 1'b0,1'b0, 5'd7, 1'b1,1'b0},  // R2 seed weak taken
    {1'b1,1'b0,1'b0, 1'b1,1'b1, 5'd7, 1'b0,1'b0},  // R6 seed wins over outcome
    {1'b0,1'b0,1'b0, 1'b1,1'b0, 5'd7, 1'b0,1'b0}   // R5 weak not-taken -> strong not-taken
  };

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    seed_en = 1'b0; seed_has_hint = 1'b0; seed_hint_taken = 1'b0; seed_idx = '0;
    upd_en = 1'b0; upd_taken = 1'b0; upd_idx = '0; lkp_idx = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count zero", int'(miss_count), 0);
    check("R1 flag low", int'(upd_mispredict), 0);
    lkp_idx = 5'd31; #1;
    check("R1 entry 31 not-taken", int'(lkp_taken), 0);
    rst = 1'b0;
    // R1: reset state is weak not-taken: one taken outcome flips it
    op(1'b0,1'b0,1'b0,5'd0, 1'b1,1'b1,5'd0, 5'd0, 1'b1,1'b1, "R1 weak not-taken after reset");

    for (int k = 0; k < NV; k++) begin
      op(VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][6:2],
         VEC[k][8], VEC[k][7], VEC[k][6:2],
         VEC[k][6:2], VEC[k][1], VEC[k][0], "R5 vector");
    end

    // R9 / R4: lookup changes with the index alone, no clock
    @(negedge clk);
    lkp_idx = 5'd3; #1;
    check("R9 lookup idx3 taken", int'(lkp_taken), 1);
    lkp_idx = 5'd7; #1;
    check("R9 lookup idx7 not-taken", int'(lkp_taken), 0);

    // R6: seed and outcome on different entries both land
    op(1'b1,1'b1,1'b1,5'd10, 1'b1,1'b1,5'd11, 5'd10, 1'b1,1'b1, "R6 seed side");
    lkp_idx = 5'd11; #1;
    check("R6 outcome side", int'(lkp_taken), 1);

    // R5 loop: strong taken survives one exit
    op(1'b1,1'b1,1'b1,5'd9, 1'b0,1'b0,5'd9, 5'd9, 1'b1,1'b0, "R2 loop seed");
    op(1'b0,1'b0,1'b0,5'd9, 1'b1,1'b1,5'd9, 5'd9, 1'b1,1'b0, "R5 loop iter");
    op(1'b0,1'b0,1'b0,5'd9, 1'b1,1'b0,5'd9, 5'd9, 1'b1,1'b1, "R5 loop exit");
    op(1'b0,1'b0,1'b0,5'd9, 1'b1,1'b1,5'd9, 5'd9, 1'b1,1'b0, "R5 loop reentry");

    // R8: alternate outcomes so each one mispredicts, past the counter max
    for (int k = 0; k < 10; k++) begin
      op(1'b0,1'b0,1'b0,5'd20, 1'b1,(k % 2 == 0),5'd20, 5'd20,
         (k % 2 == 0), 1'b1, "R8 saturation");
    end
    check("R8 saturated at max", int'(miss_count), int'(CMAX));

    // R7: idle cycle drops the flag
    @(negedge clk); @(negedge clk);
    check("R7 flag idle", int'(upd_mispredict), 0);

    // R1: reset again clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    lkp_idx = 5'd3; #1;
    check("R1 re-reset entry", int'(lkp_taken), 0);
    check("R1 re-reset count", int'(miss_count), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule